// File: doc/BRIEF.md
# Global History Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps one shift register holding the outcomes of the most recent branches, whichever branches they were. That register is joined with a few low bits of the branch address to form an index. The index picks one 2-bit saturating counter out of a table of 16K counters. A fetch stage presents a branch address and gets a taken or not-taken answer in the same cycle. It also gets the index that was used, and keeps that index until the branch resolves.

When the branch resolves, the pipeline returns the index it kept together with the real outcome. The block moves the selected counter one step toward that outcome. It also shifts the outcome into the history register. The stored index is used as given, so any history movement since the prediction does not send the update to a different counter.

The counter table is a memory and has no reset. After reset, a small controller walks the table one row per clock and writes the weakly not-taken value into every counter. The controller has two named states. In `ST_SWEEP` it clears one row each cycle, and its only transition leaves this state once the last row is written. In `ST_READY` it has no outgoing transition and stays there until the next reset. The `ready` output is high only in `ST_READY`.

Top module: `gh_predictor`

## Requirements
- R1: While reset is asserted, and during the sweep after it, `ready` and `pred_taken` are 0. `ready` goes to 1 on the 1024th rising clock edge after reset is released and stays at 1. The history is 0 at that point.
- R2: `pred_index` is `{history[7:0], pred_pc[7:2]}`. Bit 13 is the oldest recorded outcome and bits 5:0 are address bits 7:2.
- R3: `pred_taken` is 1 exactly when the counter selected by `pred_index` holds 2 or 3. Once `ready` rises, every counter holds 1, so every prediction is not-taken.
- R4: An accepted update with `upd_taken`=1 sets the counter at `upd_index` to min(3, value+1).
- R5: An accepted update with `upd_taken`=0 sets the counter at `upd_index` to max(0, value-1).
- R6: Each accepted update shifts `upd_taken` into history bit 0 and drops bit 7. When no update is accepted, the history holds its value.
- R7: An update changes only the counter named by `upd_index`. This holds even when the current history differs from the one in that index. Other counters in the same storage row are left unchanged.
- R8: Suppose a prediction and an update address the same counter in the same cycle. The prediction then shows the counter value from before that update.
- R9: Updates presented while `ready` is 0 have no effect on the history or on any counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken, same cycle as `pred_pc` |
| pred_index | output | 14 | Table index used for this prediction, kept by the caller for the update |
| upd_valid | input | 1 | An update is presented this cycle |
| upd_index | input | 14 | Index captured at prediction time for the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| ready | output | 1 | Table sweep is complete and the predictor is in use |

## Verification
`pred_taken` and `pred_index` are combinational in `pred_pc`, the history and the table. They are therefore valid in the cycle the address is driven. The bench drives just after a rising edge and compares at the following falling edge. An update takes effect at the next rising edge: the new counter value and the shifted history are first visible in the cycle after the one in which `upd_valid` was high. The bench updates its own counter and history model only after that edge. For the same-cycle case, the prediction is compared at the falling edge before the update is committed. `ready` is checked by counting rising edges from reset release, and it is expected exactly on edge 1024.

// File: rtl/gh_pkg.sv
package gh_pkg;

    localparam int CNT_W = 2;

    typedef enum logic [0:0] {
        ST_SWEEP = 1'b0,
        ST_READY = 1'b1
    } init_state_t;

    // one saturating step of a 2-bit direction counter
    function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] cur,
                                                 input logic               taken);
        logic [CNT_W-1:0] nxt;
        if (taken) begin
            nxt = (cur == {CNT_W{1'b1}}) ? cur : cur + 1'b1;
        end else begin
            nxt = (cur == '0) ? cur : cur - 1'b1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/gh_history.sv
module gh_history #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_in,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_W-2:0], shift_in};
        end
    end

    assign hist = hist_q;

endmodule

// File: rtl/gh_index.sv
module gh_index #(
    parameter int PC_W    = 32,
    parameter int HIST_W  = 8,
    parameter int PC_BITS = 6,
    parameter int PC_LSB  = 2,
    localparam int IDX_W  = HIST_W + PC_BITS
) (
    input  logic [HIST_W-1:0] hist,
    input  logic [PC_W-1:0]   pc,
    output logic [IDX_W-1:0]  idx
);

    logic [PC_BITS-1:0] pc_field;

    assign pc_field = pc[PC_LSB +: PC_BITS];
    assign idx      = {hist, pc_field};

endmodule

// File: rtl/gh_init_fsm.sv
module gh_init_fsm
    import gh_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             sweep_we,
    output logic [ROW_W-1:0] sweep_row,
    output logic             ready
);

    localparam logic [ROW_W-1:0] LAST_ROW = {ROW_W{1'b1}};

    init_state_t      state_q, state_d;
    logic [ROW_W-1:0] row_q;

    // state register and sweep row counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SWEEP;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SWEEP) begin
                row_q <= row_q + 1'b1;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SWEEP: if (row_q == LAST_ROW) state_d = ST_READY;
            ST_READY: state_d = ST_READY;
            default:  state_d = ST_SWEEP;
        endcase
    end

    // outputs
    always_comb begin
        sweep_we = 1'b0;
        ready    = 1'b0;
        unique case (state_q)
            ST_SWEEP: sweep_we = 1'b1;
            ST_READY: ready    = 1'b1;
            default:  sweep_we = 1'b0;
        endcase
    end

    assign sweep_row = row_q;

endmodule

// File: rtl/gh_table.sv
module gh_table
    import gh_pkg::*;
#(
    parameter int IDX_W  = 14,
    parameter int SLOT_W = 4,
    localparam int ROW_W    = IDX_W - SLOT_W,
    localparam int ROWS     = 1 << ROW_W,
    localparam int SLOTS    = 1 << SLOT_W,
    localparam int ROW_BITS = SLOTS * CNT_W
) (
    input  logic             clk,
    input  logic             sweep_we,
    input  logic [ROW_W-1:0] sweep_row,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    logic [ROW_BITS-1:0] rows_q [ROWS];
    logic [ROW_BITS-1:0] init_pat;
    logic [ROW_BITS-1:0] rd_row;
    logic [ROW_BITS-1:0] wr_old;
    logic [ROW_BITS-1:0] wr_new;
    logic [ROW_W-1:0]    wr_row;
    logic [SLOT_W-1:0]   wr_slot;
    logic [SLOT_W-1:0]   rd_slot;

    assign wr_row  = wr_idx[IDX_W-1:SLOT_W];
    assign wr_slot = wr_idx[SLOT_W-1:0];
    assign rd_slot = rd_idx[SLOT_W-1:0];
    assign rd_row  = rows_q[rd_idx[IDX_W-1:SLOT_W]];
    assign wr_old  = rows_q[wr_row];
    assign rd_cnt  = rd_row[rd_slot*CNT_W +: CNT_W];

    // per-slot weakly-not-taken pattern and read-modify-write lane
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign init_pat[s*CNT_W +: CNT_W] = CNT_W'(1);
        assign wr_new[s*CNT_W +: CNT_W] =
            (wr_slot == SLOT_W'(s)) ? sat_step(wr_old[s*CNT_W +: CNT_W], wr_taken)
                                    : wr_old[s*CNT_W +: CNT_W];
    end

    always_ff @(posedge clk) begin
        if (sweep_we) begin
            rows_q[sweep_row] <= init_pat;
        end else if (wr_en) begin
            rows_q[wr_row] <= wr_new;
        end
    end

endmodule

// File: rtl/gh_predictor.sv
module gh_predictor
    import gh_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int HIST_W  = 8,
    parameter int PC_BITS = 6,
    parameter int PC_LSB  = 2,
    parameter int SLOT_W  = 4,
    localparam int IDX_W  = HIST_W + PC_BITS,
    localparam int ROW_W  = IDX_W - SLOT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_index,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_index,
    input  logic             upd_taken,
    output logic             ready
);

    logic [HIST_W-1:0] hist_q;
    logic              upd_ok;
    logic              sweep_we;
    logic [ROW_W-1:0]  sweep_row;
    logic [CNT_W-1:0]  sel_cnt;

    assign upd_ok = ready & upd_valid;

    gh_init_fsm #(.ROW_W(ROW_W)) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .sweep_we  (sweep_we),
        .sweep_row (sweep_row),
        .ready     (ready)
    );

    gh_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_ok),
        .shift_in (upd_taken),
        .hist     (hist_q)
    );

    gh_index #(
        .PC_W    (PC_W),
        .HIST_W  (HIST_W),
        .PC_BITS (PC_BITS),
        .PC_LSB  (PC_LSB)
    ) u_idx (
        .hist (hist_q),
        .pc   (pred_pc),
        .idx  (pred_index)
    );

    gh_table #(.IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_tab (
        .clk       (clk),
        .sweep_we  (sweep_we),
        .sweep_row (sweep_row),
        .rd_idx    (pred_index),
        .rd_cnt    (sel_cnt),
        .wr_en     (upd_ok),
        .wr_idx    (upd_index),
        .wr_taken  (upd_taken)
    );

    assign pred_taken = ready & (sel_cnt >= CNT_W'(2));

endmodule

// File: rtl/gh_checker.sv
module gh_checker #(
    parameter int HIST_W = 8,
    parameter int IDX_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic              pred_taken,
    input logic [HIST_W-1:0] hist,
    input logic [IDX_W-1:0]  pred_index
);

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R1

    AST_SWEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (hist == '0 && !pred_taken)); // R9

    AST_INDEX_HIST: assert property (@(posedge clk) disable iff (!rst_n)
        pred_index[IDX_W-1 -: HIST_W] == hist); // R2

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && upd_valid) |=> hist == {$past(hist[HIST_W-2:0]), $past(upd_taken)}); // R6

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && upd_valid) |=> $stable(hist)); // R6

endmodule

bind gh_predictor gh_checker #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .pred_taken (pred_taken),
    .hist       (hist_q),
    .pred_index (pred_index)
);

// File: tb/tb_gh_predictor.sv
module tb_gh_predictor;

    localparam int CLK_PERIOD = 10;
    localparam int SCRATCH    = 14'h3FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic [13:0] pred_index;
    logic        upd_valid = 1'b0;
    logic [13:0] upd_index = '0;
    logic        upd_taken = 1'b0;
    logic        ready;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        exp_taken;
        logic [13:0] exp_idx;
        string       tag;
    } item_t;

    item_t      sb_q[$];
    logic [1:0] m_cnt [int];
    logic [7:0] m_hist = '0;

    gh_predictor dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .pred_index (pred_index),
        .upd_valid  (upd_valid),
        .upd_index  (upd_index),
        .upd_taken  (upd_taken),
        .ready      (ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] model_get(input int i);
        return m_cnt.exists(i) ? m_cnt[i] : 2'd1;
    endfunction

    function automatic void model_upd(input int i, input logic t);
        logic [1:0] c;
        c = model_get(i);
        if (t) c = (c == 2'd3) ? c : c + 2'd1;
        else   c = (c == 2'd0) ? c : c - 2'd1;
        m_cnt[i] = c;
        m_hist   = {m_hist[6:0], t};
    endfunction

    function automatic item_t expect_for(input logic [31:0] pc, input string tag);
        item_t it;
        it.exp_idx   = {m_hist, pc[7:2]};
        it.exp_taken = (model_get(int'(it.exp_idx)) >= 2'd2);
        it.tag       = tag;
        return it;
    endfunction

    // driver: present an address, queue its expected result
    task automatic probe(input logic [31:0] pc, input string tag);
        @(posedge clk); #1;
        pred_pc = pc;
        sb_q.push_back(expect_for(pc, tag));
    endtask

    task automatic upd(input logic [13:0] idx, input logic t);
        @(posedge clk); #1;
        upd_valid = 1'b1; upd_index = idx; upd_taken = t;
        @(posedge clk); #1;
        upd_valid = 1'b0;
        model_upd(int'(idx), t);
    endtask

    // prediction and update on the same counter in one cycle
    task automatic probe_and_upd(input logic [31:0] pc, input logic t, input string tag);
        item_t it;
        @(posedge clk); #1;
        it = expect_for(pc, tag);
        pred_pc = pc;
        upd_valid = 1'b1; upd_index = it.exp_idx; upd_taken = t;
        sb_q.push_back(it);
        @(posedge clk); #1;
        upd_valid = 1'b0;
        model_upd(int'(it.exp_idx), t);
    endtask

    task automatic set_hist(input logic [7:0] h);
        for (int i = 7; i >= 0; i--) upd(SCRATCH[13:0], h[i]);
    endtask

    // monitor: compare queued expectations at the falling edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check({it.tag, " taken"}, {31'd0, pred_taken}, {31'd0, it.exp_taken});
                check({it.tag, " index"}, {18'd0, pred_index}, {18'd0, it.exp_idx});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ready in reset", {31'd0, ready}, 32'd0);
        check("R1 pred_taken in reset", {31'd0, pred_taken}, 32'd0);
        rst_n = 1'b1;
        // R9: updates during the sweep must be dropped
        upd_valid = 1'b1; upd_taken = 1'b1; upd_index = '0;
        n = 0;
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            if (n == 20) upd_valid = 1'b0;
            if (n == 500) check("R1 ready low mid sweep", {31'd0, ready}, 32'd0);
            if (ready || n > 3000) break;
        end
        upd_valid = 1'b0;
        check("R1 ready edge count", n, 1024);
        probe(32'h0, "R9 R3 R1 after sweep");
        probe(32'hFC, "R2 R3 pc field");
        probe(32'h1234_5679, "R2 low bits ignored");
        // R4: repeated taken, saturating at 3
        upd(14'h005, 1'b1); upd(14'h005, 1'b1); upd(14'h005, 1'b1);
        probe(32'h14, "R6 R2 history 111");
        set_hist(8'h00);
        probe(32'h14, "R4 R7 taken after 3 incs");
        probe(32'h10, "R7 neighbour slot untouched");
        upd(14'h005, 1'b0);
        set_hist(8'h00);
        probe(32'h14, "R4 saturated then dec");
        upd(14'h005, 1'b0); upd(14'h005, 1'b0); upd(14'h005, 1'b0);
        set_hist(8'h00);
        probe(32'h14, "R5 dec to zero");
        upd(14'h005, 1'b1);
        set_hist(8'h00);
        probe(32'h14, "R5 saturated at zero then inc");
        // R6: walk a history pattern and read it back through the index
        set_hist(8'hA5);
        probe(32'h8, "R6 R2 history A5");
        upd(14'h0123, 1'b1);
        probe(32'h8, "R6 shift in 1");
        upd(14'h0123, 1'b0);
        probe(32'h8, "R6 shift in 0");
        // R8: same-cycle hit shows the old value
        set_hist(8'h3C);
        probe_and_upd(32'h20, 1'b1, "R8 same cycle first");
        set_hist(8'h3C);
        probe_and_upd(32'h20, 1'b1, "R8 same cycle second");
        set_hist(8'h3C);
        probe(32'h20, "R8 R4 after both");
        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule